// File: doc/BRIEF.md
# Serial DAC Control Front End

This block is the digital front end of a single-channel precision DAC. A host talks to it over a four-wire serial link: serial clock, data in, active-low frame select and a data-out line with an enable. Every frame carries a direction bit, a register address and a data field. Writes to the code register fill an input (staging) register. The staged value becomes the active DAC code in one of two ways: a falling edge on the load strobe, or the end of the write frame when frame-load mode is selected in the control register. A read frame picks up the addressed register. Its contents come back on the data-out line during the following frame.

The block runs on one system clock. The serial pins, the frame select and the load strobe pass through synchronizers, and all edges are found by comparing samples. An active-low clear input forces the staging and active code registers to zero without waiting for a clock. Frames whose falling-clock count is not exactly the frame length are thrown away and raise an alarm flag. The code width is a parameter (16, 18 or 20 bits), and the code is always left-justified in the data field.

Top module: `dac_serial_front`

## Requirements
- R1: After a synchronous reset (rst_n low on a clock edge), dac_code is 0, alarm is 0, sdo_oe is 0, and the control register reads back as all zeros.
- R2: A frame is 32 bits, MSB first, sampled on falling edges of sclk while sync_n is low. Bit 31 is the direction (0 write, 1 read), bits 30:24 are the address, and bits 23:0 are the data. Edges on sclk while sync_n is high are ignored.
- R3: sdo_oe is low whenever sync_n has been high for the last 4 clock cycles, and it is high inside a frame.
- R4: A valid write to address 0x01 loads data[23 -: RES] into the staging register. With frame-load mode off, dac_code does not change.
- R5: A falling edge on ldac_n copies the staging register to dac_code within 3 clock cycles.
- R6: Control register at address 0x02: bit 1 is frame-load mode. When it is set, a valid write to address 0x01 also updates dac_code within 3 clock cycles after sync_n rises.
- R7: While clr_n is low, dac_code and the staging register are 0 at once, with no clock edge needed, and ldac_n has no effect.
- R8: A frame with fewer or more than 32 falling sclk edges changes no register, but it sets alarm.
- R9: Any valid write to the control register clears alarm. Control reads return {21'b0, alarm, frame-load, sdo-edge} in the data field.
- R10: After a valid read frame to address A, the next frame shifts out {1'b1, A, value} on sdo. Address 0x01 gives {staging code, zero padding}, address 0x02 gives the control word, and any other address gives zero data.
- R11: Control bit 0 (sdo-edge) selects when sdo advances. When it is 0, sdo moves to the next bit after each rising sclk edge. When it is 1, sdo moves after each falling sclk edge.
- R12: The code width RES sets dac_code width. The code is taken from the top RES bits of the 24-bit data field, and the lower bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock, idles high |
| sdin | input | 1 | Serial data in |
| sync_n | input | 1 | Active-low frame select |
| ldac_n | input | 1 | Active-low load strobe (acts on its falling edge) |
| clr_n | input | 1 | Asynchronous active-low code clear |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo (tri-state control) |
| alarm | output | 1 | Set by a discarded frame |
| dac_code | output | RES | Active DAC code |

## Verification
Every pin event passes through two synchronizer stages and one edge-detect register. A register update caused by sync_n rising or by an ldac_n fall therefore appears at most 3 clock cycles later. The bench holds each serial phase for 8 clocks and waits 24 clocks after each frame before it compares anything. sdo is sampled twice per bit: once at the end of the high phase, and once at the end of the low phase, before the next rising edge. In the low-phase sample the bit has already moved if sdo advances on falling edges, and has not yet moved if it advances on rising edges. The asynchronous clear is checked 1 ns after clr_n falls, before any clock edge.

// File: rtl/dac_fe_pkg.sv
// Shared frame layout and register addresses for the serial DAC front end.
package dac_fe_pkg;
    localparam int FRAME_W = 32;
    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 24;
    localparam logic [ADDR_W-1:0] ADDR_CODE = 7'h01;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 7'h02;
endpackage

// File: rtl/dac_fe_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes each bit is independent; RST_VAL sets the idle level seen after reset.
module dac_fe_sync #(
    parameter int W = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] pipe [STAGES];

    // Shift the pin samples through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d_async;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q_sync = pipe[STAGES-1];
endmodule

// File: rtl/dac_fe_shift.sv
// Serial frame engine: captures sdin on falling sclk edges inside a frame,
// counts bits, classifies the frame at sync_n rise, and shifts the readback
// word out on the edge picked by sdo_fall. Inputs are already synchronized.
module dac_fe_shift
    import dac_fe_pkg::*;
#(
    parameter int FW = FRAME_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_s,
    input  logic          sdin_s,
    input  logic          sync_n_s,
    input  logic          sdo_fall,
    input  logic          load_en,
    input  logic [FW-1:0] load_word,
    output logic [FW-1:0] frame_word,
    output logic          frame_ok,
    output logic          frame_bad,
    output logic          sdo,
    output logic          sdo_oe
);
    localparam int CNT_W = $clog2(FW + 2);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FW + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FW);

    logic             sclk_q, sync_q;
    logic [FW-1:0]    in_sr, out_sr;
    logic [CNT_W-1:0] cnt;
    logic             fall, rise, in_frame, end_evt, out_step;

    assign fall     = sclk_q & ~sclk_s;
    assign rise     = ~sclk_q & sclk_s;
    assign in_frame = ~sync_n_s;
    assign end_evt  = ~sync_q & sync_n_s;
    assign out_step = in_frame & (sdo_fall ? fall : (rise & (cnt != '0)));

    // Keep the previous sample of sclk and sync_n for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            sync_q <= sync_n_s;
        end
    end

    // Capture input bits and count falling edges, saturating past a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_sr <= '0;
            cnt   <= '0;
        end else if (end_evt) begin
            cnt <= '0;
        end else if (in_frame && fall) begin
            in_sr <= {in_sr[FW-2:0], sdin_s};
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        end
    end

    // Load readback data at a read frame's end, otherwise shift it out.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_sr <= '0;
        else if (load_en)  out_sr <= load_word;
        else if (out_step) out_sr <= {out_sr[FW-2:0], 1'b0};
    end

    assign frame_word = in_sr;
    assign frame_ok   = end_evt & (cnt == CNT_FULL);
    assign frame_bad  = end_evt & (cnt != CNT_FULL);
    assign sdo        = out_sr[FW-1];
    assign sdo_oe     = in_frame;
endmodule

// File: rtl/dac_fe_regs.sv
// Register file: staging code, active code, control bits and alarm.
// clr_n acts asynchronously on both code registers; the rest resets synchronously.
module dac_fe_regs
    import dac_fe_pkg::*;
#(
    parameter int RES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              ldac_n_s,
    input  logic              frame_ok,
    input  logic              frame_bad,
    input  logic [FRAME_W-1:0] frame_word,
    output logic [DATA_W-1:0] rd_data,
    output logic [RES-1:0]    dac_code,
    output logic              sdo_fall,
    output logic              alarm,
    output logic              ldac_evt
);
    localparam int PAD_W = DATA_W - RES;

    logic              ldac_q, frame_load;
    logic [RES-1:0]    stage_q, active_q, wr_code;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              is_read, wr_code_en, wr_ctrl_en;
    logic              unused_bits;

    assign is_read    = frame_word[FRAME_W-1];
    assign addr       = frame_word[FRAME_W-2 -: ADDR_W];
    assign data       = frame_word[DATA_W-1:0];
    assign wr_code    = data[DATA_W-1 -: RES];
    assign wr_code_en = frame_ok & ~is_read & (addr == ADDR_CODE);
    assign wr_ctrl_en = frame_ok & ~is_read & (addr == ADDR_CTRL);
    assign ldac_evt   = ldac_q & ~ldac_n_s;
    assign unused_bits = ^data;

    // Track the load strobe for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ldac_q <= 1'b1;
        else        ldac_q <= ldac_n_s;
    end

    // Staging and active code registers with asynchronous clear.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            stage_q  <= '0;
            active_q <= '0;
        end else if (!rst_n) begin
            stage_q  <= '0;
            active_q <= '0;
        end else begin
            if (wr_code_en) stage_q <= wr_code;
            if (wr_code_en && frame_load) active_q <= wr_code;
            else if (ldac_evt)            active_q <= stage_q;
        end
    end

    // Control bits written by a control-register frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo_fall   <= 1'b0;
            frame_load <= 1'b0;
        end else if (wr_ctrl_en) begin
            sdo_fall   <= data[0];
            frame_load <= data[1];
        end
    end

    // Alarm is set by a discarded frame and cleared by a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)          alarm <= 1'b0;
        else if (wr_ctrl_en) alarm <= 1'b0;
        else if (frame_bad)  alarm <= 1'b1;
    end

    // Readback multiplexer for the address in the current frame.
    always_comb begin
        case (addr)
            ADDR_CODE: rd_data = {stage_q, {PAD_W{1'b0}}};
            ADDR_CTRL: rd_data = {{(DATA_W-3){1'b0}}, alarm, frame_load, sdo_fall};
            default:   rd_data = '0;
        endcase
    end

    assign dac_code = active_q;
endmodule

// File: rtl/dac_serial_front.sv
// Top of the serial DAC front end: synchronizes the pins, runs the frame
// engine and the register file, and routes read data back to the shifter.
// Assumes sclk idles high and each sclk phase lasts at least 4 clk cycles.
module dac_serial_front
    import dac_fe_pkg::*;
#(
    parameter int RES = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sclk,
    input  logic           sdin,
    input  logic           sync_n,
    input  logic           ldac_n,
    input  logic           clr_n,
    output logic           sdo,
    output logic           sdo_oe,
    output logic           alarm,
    output logic [RES-1:0] dac_code
);
    logic [3:0]         pins_s;
    logic               sclk_s, sdin_s, sync_n_s, ldac_n_s;
    logic [FRAME_W-1:0] frame_word, load_word;
    logic [DATA_W-1:0]  rd_data;
    logic               frame_ok, frame_bad, sdo_fall, load_en, ldac_evt;

    dac_fe_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1011)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async({sclk, sdin, sync_n, ldac_n}),
        .q_sync(pins_s)
    );
    assign {sclk_s, sdin_s, sync_n_s, ldac_n_s} = pins_s;

    assign load_en   = frame_ok & frame_word[FRAME_W-1];
    assign load_word = {1'b1, frame_word[FRAME_W-2 -: ADDR_W], rd_data};

    dac_fe_shift #(.FW(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .sclk_s(sclk_s), .sdin_s(sdin_s), .sync_n_s(sync_n_s),
        .sdo_fall(sdo_fall), .load_en(load_en), .load_word(load_word),
        .frame_word(frame_word), .frame_ok(frame_ok), .frame_bad(frame_bad),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    dac_fe_regs #(.RES(RES)) u_regs (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ldac_n_s(ldac_n_s),
        .frame_ok(frame_ok), .frame_bad(frame_bad), .frame_word(frame_word),
        .rd_data(rd_data), .dac_code(dac_code), .sdo_fall(sdo_fall),
        .alarm(alarm), .ldac_evt(ldac_evt)
    );
endmodule

// File: rtl/dac_serial_front_chk.sv
// Property checker for dac_serial_front, attached with bind.
module dac_serial_front_chk #(
    parameter int RES = 20
) (
    input logic           clk,
    input logic           rst_n,
    input logic           clr_n,
    input logic           sync_n,
    input logic           sdo_oe,
    input logic           alarm,
    input logic           frame_ok,
    input logic           frame_bad,
    input logic           ldac_evt,
    input logic [RES-1:0] dac_code
);
    // R3: no drive on sdo after sync_n has stayed high long enough
    p_sdo_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_n && $past(sync_n) && $past(sync_n, 2) && $past(sync_n, 3)) |-> !sdo_oe);

    // R7: clear input holds the code at zero
    p_clr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (dac_code == '0));

    // R5, R4, R6: the code only moves after a load strobe or a good frame
    p_code_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && $past(clr_n) && (dac_code != $past(dac_code)))
            |-> ($past(frame_ok) || $past(ldac_evt)));

    // R8: a discarded frame leaves the code untouched
    p_bad_keeps_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_bad && !ldac_evt && clr_n) |=> (!clr_n || dac_code == $past(dac_code)));

    // R8: a discarded frame raises the alarm
    p_alarm_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_bad |=> alarm);

    // R2: a frame end is classified exactly one way
    p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_ok && frame_bad));
endmodule

bind dac_serial_front dac_serial_front_chk #(.RES(RES)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .sync_n(sync_n),
    .sdo_oe(sdo_oe), .alarm(alarm), .frame_ok(frame_ok),
    .frame_bad(frame_bad), .ldac_evt(ldac_evt), .dac_code(dac_code)
);

// File: tb/dac_serial_front_test.sv
// Self-checking bench for dac_serial_front.
module dac_serial_front_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 8;
    localparam int RES = 20;
    localparam int NVEC = 6;
    localparam logic [23:0] VEC_DATA [NVEC] = '{
        24'hFFFFF0, 24'h000000, 24'h800000, 24'h00001F, 24'h123456, 24'hABCDEF
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0, sclk = 1'b1, sdin = 1'b0, sync_n = 1'b1;
    logic ldac_n = 1'b1, clr_n = 1'b1;
    logic sdo, sdo_oe, alarm;
    logic [RES-1:0] dac_code;

    int n_vec = 0, n_bad = 0;
    bit done = 1'b0;
    logic oe_mid;
    logic [31:0] rx, rxl;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_serial_front #(.RES(RES)) uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdin(sdin), .sync_n(sync_n),
        .ldac_n(ldac_n), .clr_n(clr_n), .sdo(sdo), .sdo_oe(sdo_oe),
        .alarm(alarm), .dac_code(dac_code)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Send nbits of w (MSB first, zeros past bit 0); record sdo per bit.
    task automatic frame(input logic [31:0] w, input int nbits);
        rx = '0;
        rxl = '0;
        sync_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            sdin = (i < 32) ? w[31-i] : 1'b0;
            wait_clk(HALF);
            rx = {rx[30:0], sdo};
            sclk = 1'b0;
            wait_clk(HALF);
            rxl = {rxl[30:0], sdo};
            if (i == nbits / 2) oe_mid = sdo_oe;
            sclk = 1'b1;
        end
        wait_clk(HALF);
        sync_n = 1'b1;
        wait_clk(3 * HALF);
    endtask

    task automatic read_reg(input logic [6:0] a);
        frame({1'b1, a, 24'h0}, 32);
        frame(32'h0000_0000, 32);
    endtask

    task automatic pulse_ldac;
        ldac_n = 1'b0;
        wait_clk(4);
        ldac_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        wait_clk(150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        // R1: reset state at the ports
        check("R1 code", 32'(dac_code), 32'h0);
        check("R1 alarm", 32'(alarm), 32'h0);
        check("R1 oe", 32'(sdo_oe), 32'h0);
        read_reg(7'h02);
        check("R1 ctrl readback", rx, 32'h8200_0000);
        check("R3 oe inside frame", 32'(oe_mid), 32'h1);
        check("R3 oe after frame", 32'(sdo_oe), 32'h0);

        // R4 / R5: staged write, then load strobe
        frame(32'h015A_5A50, 32);
        check("R4 code held", 32'(dac_code), 32'h0);
        pulse_ldac();
        check("R5 code loaded", 32'(dac_code), 32'h5A5A5);

        // R2: sclk toggling with sync_n high must not disturb the next frame
        sdin = 1'b1;
        for (int k = 0; k < 40; k++) begin
            sclk = ~sclk;
            wait_clk(HALF);
        end
        frame(32'h0101_2340, 32);
        pulse_ldac();
        check("R2 ignore idle sclk", 32'(dac_code), 32'h01234);

        // R6 / R12: frame-load mode, table of codes
        frame(32'h0200_0002, 32);
        for (int v = 0; v < NVEC; v++) begin
            frame({8'h01, VEC_DATA[v]}, 32);
            check("R6 R12 frame load", 32'(dac_code), 32'(VEC_DATA[v][23:4]));
        end

        // R8: short frame discarded, alarm set
        frame(32'h0111_1110, 31);
        check("R8 short keeps code", 32'(dac_code), 32'hABCDE);
        check("R8 short alarm", 32'(alarm), 32'h1);
        read_reg(7'h02);
        check("R9 ctrl shows alarm", rx, 32'h8200_0006);
        frame(32'h0200_0002, 32);
        check("R9 alarm cleared", 32'(alarm), 32'h0);
        frame(32'h0111_1110, 33);
        check("R8 long keeps code", 32'(dac_code), 32'hABCDE);
        check("R8 long alarm", 32'(alarm), 32'h1);
        frame(32'h0200_0002, 32);

        // R10 / R11: readback, sdo on rising edges
        read_reg(7'h01);
        check("R10 code readback", rx, 32'h81AB_CDE0);
        check("R11 rising-edge sdo", rxl, rx);
        read_reg(7'h05);
        check("R10 unknown address", rx, 32'h8500_0000);

        // R11: sdo on falling edges
        frame(32'h0200_0003, 32);
        read_reg(7'h01);
        check("R11 falling readback", rx, 32'h81AB_CDE0);
        check("R11 falling-edge sdo", rxl, {rx[30:0], 1'b0});
        frame(32'h0200_0002, 32);

        // R7: asynchronous clear
        clr_n = 1'b0;
        #1;
        check("R7 async clear", 32'(dac_code), 32'h0);
        wait_clk(2);
        pulse_ldac();
        check("R7 ldac blocked", 32'(dac_code), 32'h0);
        clr_n = 1'b1;
        wait_clk(2);
        pulse_ldac();
        check("R7 staging cleared", 32'(dac_code), 32'h0);

        // R1: reset after activity
        frame(32'h0200_0003, 32);
        frame(32'h0177_7770, 32);
        frame(32'h0111_1110, 30);
        rst_n = 1'b0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        check("R1 code after reset", 32'(dac_code), 32'h0);
        check("R1 alarm after reset", 32'(alarm), 32'h0);
        read_reg(7'h02);
        check("R1 ctrl after reset", rx, 32'h8200_0000);

        finish_run();
    end
endmodule